// File: doc/BRIEF.md
# Index/Data-Port Watchdog Timer

This block is a countdown watchdog whose settings sit behind a pair of byte ports. Software writes a register number to the index port, then reads or writes that register through the data port. Configuration access starts closed. Two back-to-back index writes of a key byte open it, and a different key byte written to the index port closes it again. The watchdog registers only respond while a page-select register holds the watchdog page number.

Once it is enabled, the 8-bit counter steps down by one for every time unit. The unit is either a seconds tick from outside the block or that tick divided down to minutes. When the counter steps from one to zero, the block raises a single-cycle reset pulse and then holds at zero until something reloads it. A data-port write to the counter register reloads it. Keyboard or mouse activity can also reload it, restoring the last value written, if the matching source bit is set.

The bus side uses plain one-cycle strobes. Every strobe is accepted in the cycle it is presented, so there is no back-pressure. Each read strobe produces exactly one `rvalid` beat one cycle later. The bench drives the ports from a scoreboard.

Top module: `idxwdt_top`

## Requirements
- R1: After reset, configuration access is closed. It opens only when two consecutive index writes both carry 0x87; any other index write in between restarts the sequence. `rvalid` is high exactly one cycle after `dat_rd`, and a read made while access is closed returns 0xFF.
- R2: A data-port write made while access is closed changes no register.
- R3: An index write of 0xAA closes access. The counter keeps running while access is closed.
- R4: Index 0x07 holds the page number, and reading it returns that number. Indices 0x30, 0xF5, 0xF6 and 0xF7 respond only while the page is 0x08. On any other page, writes to them are ignored and reads of them return 0x00.
- R5: A write to index 0xF6 loads the count and the reload value. A read of 0xF6 returns the live count. While the watchdog is enabled, each unit tick lowers the count by exactly one.
- R6: When a unit tick takes the count from 1 to 0, `wdt_reset` is high for exactly one cycle, in the cycle after the edge that sampled the tick.
- R7: At zero the count stays at zero and produces no further pulses until a load or a reload.
- R8: Bit 0 of index 0x30 enables counting. While it is 0, the count is frozen. The other bits of 0x30 read as 0.
- R9: Bit 3 of index 0xF5 selects minutes when it is 1. In minutes mode, the count drops once per 60 `sec_tick` pulses, counted from the last load. The other bits of 0xF5 read as 0.
- R10: Bit 6 of index 0xF7 lets a `kbd_evt` pulse reload the count with the reload value, and bit 7 does the same for `mouse_evt`. An event whose bit is clear has no effect. The other bits of 0xF7 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_wr | input | 1 | Index-port write strobe |
| dat_wr | input | 1 | Data-port write strobe |
| dat_rd | input | 1 | Data-port read strobe |
| wdata | input | 8 | Write byte for either port |
| rdata | output | 8 | Read byte, valid with `rvalid` |
| rvalid | output | 1 | Read result valid, one cycle after `dat_rd` |
| sec_tick | input | 1 | One pulse per second |
| kbd_evt | input | 1 | Keyboard activity pulse |
| mouse_evt | input | 1 | Mouse activity pulse |
| wdt_reset | output | 1 | One-cycle reset pulse on expiry |

## Verification
On every cycle, the assertions check these behaviours:
- the read latency, and the 0xFF answer while access is closed;
- that access opens only after a 0x87 index write;
- that the count only steps down by one unless it is loaded;
- the freeze while disabled;
- the hold at zero;
- the single-cycle expiry pulse.

Other behaviours depend on a sequence of writes and can only be shown by the bench scenarios:
- the broken-key sequence;
- the page gating;
- the masking of register bits;
- the divide-by-60 minutes timing;
- reload by keyboard or mouse event depending on the source bits;
- counting on after access is closed.

// File: rtl/idxwdt_pkg.sv
package idxwdt_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] KEY_OPEN  = 8'h87;
  localparam logic [BYTE_W-1:0] KEY_CLOSE = 8'hAA;
  localparam logic [BYTE_W-1:0] IX_PAGE   = 8'h07;
  localparam logic [BYTE_W-1:0] PG_WDT    = 8'h08;
  localparam logic [BYTE_W-1:0] IX_ENA    = 8'h30;
  localparam logic [BYTE_W-1:0] IX_UNIT   = 8'hF5;
  localparam logic [BYTE_W-1:0] IX_COUNT  = 8'hF6;
  localparam logic [BYTE_W-1:0] IX_SRC    = 8'hF7;
  localparam logic [BYTE_W-1:0] CLOSED_RD = 8'hFF;

  localparam int ENA_BIT   = 0;
  localparam int UNIT_BIT  = 3;
  localparam int KBD_BIT   = 6;
  localparam int MOUSE_BIT = 7;

  typedef enum logic [1:0] {
    GATE_SHUT = 2'd0,
    GATE_HALF = 2'd1,
    GATE_OPEN = 2'd2
  } gate_state_e;

  typedef struct packed {
    logic ena;
    logic minutes;
    logic kbd_rl;
    logic mouse_rl;
  } wdt_cfg_t;
endpackage

// File: rtl/idxwdt_gate.sv
module idxwdt_gate
  import idxwdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              open,
  output logic              idx_take
);
  gate_state_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= GATE_SHUT;
    end else if (idx_wr) begin
      case (st_q)
        GATE_SHUT: st_q <= (wdata == KEY_OPEN) ? GATE_HALF : GATE_SHUT;
        GATE_HALF: st_q <= (wdata == KEY_OPEN) ? GATE_OPEN : GATE_SHUT;
        GATE_OPEN: if (wdata == KEY_CLOSE) st_q <= GATE_SHUT;
        default:   st_q <= GATE_SHUT;
      endcase
    end
  end

  assign open     = (st_q == GATE_OPEN);
  assign idx_take = idx_wr && open && (wdata != KEY_CLOSE);
endmodule

// File: rtl/idxwdt_regs.sv
module idxwdt_regs
  import idxwdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open,
  input  logic              idx_take,
  input  logic              dat_wr,
  input  logic              dat_rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] live_count,
  output wdt_cfg_t          cfg,
  output logic              cnt_wr,
  output logic [BYTE_W-1:0] rdata,
  output logic              rvalid
);
  logic [BYTE_W-1:0] index_q;
  logic [BYTE_W-1:0] page_q;
  logic              wdt_page;
  logic              bank_wr;
  logic [BYTE_W-1:0] rd_mux;
  logic [BYTE_W-1:0] rdata_q;
  logic              rvalid_q;
  wdt_cfg_t          cfg_q;

  assign wdt_page = (page_q == PG_WDT);
  assign bank_wr  = dat_wr && open && wdt_page;
  assign cnt_wr   = bank_wr && (index_q == IX_COUNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q <= '0;
      page_q  <= '0;
    end else begin
      if (idx_take) index_q <= wdata;
      if (dat_wr && open && index_q == IX_PAGE) page_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (bank_wr) begin
      case (index_q)
        IX_ENA:  cfg_q.ena <= wdata[ENA_BIT];
        IX_UNIT: cfg_q.minutes <= wdata[UNIT_BIT];
        IX_SRC: begin
          cfg_q.kbd_rl   <= wdata[KBD_BIT];
          cfg_q.mouse_rl <= wdata[MOUSE_BIT];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    if (!open) begin
      rd_mux = CLOSED_RD;
    end else if (index_q == IX_PAGE) begin
      rd_mux = page_q;
    end else if (wdt_page) begin
      case (index_q)
        IX_ENA:   rd_mux[ENA_BIT] = cfg_q.ena;
        IX_UNIT:  rd_mux[UNIT_BIT] = cfg_q.minutes;
        IX_COUNT: rd_mux = live_count;
        IX_SRC: begin
          rd_mux[KBD_BIT]   = cfg_q.kbd_rl;
          rd_mux[MOUSE_BIT] = cfg_q.mouse_rl;
        end
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= dat_rd;
      if (dat_rd) rdata_q <= rd_mux;
    end
  end

  assign cfg    = cfg_q;
  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;
endmodule

// File: rtl/idxwdt_prescale.sv
module idxwdt_prescale #(
  parameter int unsigned DIV = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic tick_in,
  output logic tick_out
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV > 1) begin : g_div
      logic [PW-1:0] pc_q;
      logic          wrap;

      assign wrap     = (pc_q == PW'(DIV - 1));
      assign tick_out = tick_in && run && wrap;

      always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
          pc_q <= '0;
        end else if (run && tick_in) begin
          pc_q <= wrap ? '0 : pc_q + 1'b1;
        end
      end
    end else begin : g_pass
      assign tick_out = tick_in && run;
    end
  endgenerate
endmodule

// File: rtl/idxwdt_countdown.sv
module idxwdt_countdown
  import idxwdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              reload,
  input  logic              ena,
  input  logic              unit_tick,
  output logic [BYTE_W-1:0] count,
  output logic              fire
);
  logic [BYTE_W-1:0] count_q;
  logic [BYTE_W-1:0] keep_q;
  logic              fire_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      keep_q  <= '0;
      fire_q  <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (load) begin
        count_q <= load_val;
        keep_q  <= load_val;
      end else if (reload) begin
        count_q <= keep_q;
      end else if (ena && unit_tick && count_q != '0) begin
        count_q <= count_q - 1'b1;
        if (count_q == BYTE_W'(1)) fire_q <= 1'b1;
      end
    end
  end

  assign count = count_q;
  assign fire  = fire_q;
endmodule

// File: rtl/idxwdt_top.sv
module idxwdt_top
  import idxwdt_pkg::*;
#(
  parameter int unsigned MIN_DIV = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic       dat_wr,
  input  logic       dat_rd,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rvalid,
  input  logic       sec_tick,
  input  logic       kbd_evt,
  input  logic       mouse_evt,
  output logic       wdt_reset
);
  logic              cfg_open;
  logic              idx_take;
  logic              cnt_wr;
  logic              ev_reload;
  logic              any_load;
  logic              min_tick;
  logic              unit_tick;
  logic              wdt_en;
  logic [BYTE_W-1:0] count;
  wdt_cfg_t          cfg;

  idxwdt_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_wr   (idx_wr),
    .wdata    (wdata),
    .open     (cfg_open),
    .idx_take (idx_take)
  );

  idxwdt_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .open       (cfg_open),
    .idx_take   (idx_take),
    .dat_wr     (dat_wr),
    .dat_rd     (dat_rd),
    .wdata      (wdata),
    .live_count (count),
    .cfg        (cfg),
    .cnt_wr     (cnt_wr),
    .rdata      (rdata),
    .rvalid     (rvalid)
  );

  assign wdt_en    = cfg.ena;
  assign ev_reload = (kbd_evt && cfg.kbd_rl) || (mouse_evt && cfg.mouse_rl);
  assign any_load  = cnt_wr || ev_reload;

  idxwdt_prescale #(.DIV(MIN_DIV)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (any_load || !cfg.minutes),
    .run      (wdt_en),
    .tick_in  (sec_tick),
    .tick_out (min_tick)
  );

  assign unit_tick = cfg.minutes ? min_tick : sec_tick;

  idxwdt_countdown u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cnt_wr),
    .load_val  (wdata),
    .reload    (ev_reload),
    .ena       (wdt_en),
    .unit_tick (unit_tick),
    .count     (count),
    .fire      (wdt_reset)
  );
endmodule

// File: rtl/idxwdt_chk.sv
module idxwdt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       idx_wr,
  input logic [7:0] wdata,
  input logic       dat_rd,
  input logic       rvalid,
  input logic [7:0] rdata,
  input logic       wdt_reset,
  input logic       cfg_open,
  input logic       wdt_en,
  input logic [7:0] count,
  input logic       cnt_load
);
  assert_rvalid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid == $past(dat_rd));

  assert_closed_reads_ff_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !$past(cfg_open)) |-> rdata == 8'hFF);

  assert_open_after_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(idx_wr && wdata == 8'h87));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count) && !$past(cnt_load)) |-> count == $past(count) - 8'd1);

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |=> !wdt_reset);

  assert_pulse_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_reset) |-> count == 8'd0);

  assert_hold_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(count) == 8'd0 && !$past(cnt_load)) |-> (count == 8'd0 && !wdt_reset));

  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wdt_en) && !$past(cnt_load)) |-> $stable(count));
endmodule

bind idxwdt_top idxwdt_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .idx_wr    (idx_wr),
  .wdata     (wdata),
  .dat_rd    (dat_rd),
  .rvalid    (rvalid),
  .rdata     (rdata),
  .wdt_reset (wdt_reset),
  .cfg_open  (cfg_open),
  .wdt_en    (wdt_en),
  .count     (count),
  .cnt_load  (any_load)
);

// File: tb/idxwdt_top_tb_top.sv
module idxwdt_top_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       idx_wr = 1'b0, dat_wr = 1'b0, dat_rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rvalid;
  logic       sec_tick = 1'b0, kbd_evt = 1'b0, mouse_evt = 1'b0;
  logic       wdt_reset;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  idxwdt_top dut_i (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .dat_wr(dat_wr), .dat_rd(dat_rd),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .sec_tick(sec_tick),
    .kbd_evt(kbd_evt), .mouse_evt(mouse_evt), .wdt_reset(wdt_reset)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every read beat.
  always @(negedge clk) begin
    if (rst_n && wdt_reset) pulses++;
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        check("R1 unexpected rvalid", 8'h01, 8'h00);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic idx_write(logic [7:0] v);
    @(negedge clk); idx_wr = 1'b1; wdata = v;
    @(negedge clk); idx_wr = 1'b0;
  endtask

  task automatic dat_write(logic [7:0] v);
    @(negedge clk); dat_wr = 1'b1; wdata = v;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic expect_read(string tag, logic [7:0] exp);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); dat_rd = 1'b1;
    @(negedge clk); dat_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic reg_write(logic [7:0] ix, logic [7:0] v);
    idx_write(ix); dat_write(v);
  endtask

  task automatic reg_read(string tag, logic [7:0] ix, logic [7:0] exp);
    idx_write(ix); expect_read(tag, exp);
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic pulse_evt(bit mouse);
    @(negedge clk); if (mouse) mouse_evt = 1'b1; else kbd_evt = 1'b1;
    @(negedge clk); mouse_evt = 1'b0; kbd_evt = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R6 reset pulse low in reset", {7'b0, wdt_reset}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rvalid low after reset", {7'b0, rvalid}, 8'h00);
    expect_read("R1 closed read", 8'hFF);

    // R2: data write while closed must not set the page
    idx_write(8'h07); dat_write(8'h08);
    // R1: broken key sequence keeps access closed
    idx_write(8'h87); idx_write(8'h55); idx_write(8'h87); idx_write(8'h00);
    expect_read("R1 broken key stays closed", 8'hFF);
    idx_write(8'h87); idx_write(8'h87);
    reg_read("R2 page untouched by closed write", 8'h07, 8'h00);

    // R4: bank gated by page
    reg_write(8'h30, 8'h01);
    reg_read("R4 enable read off page", 8'h30, 8'h00);
    reg_write(8'h07, 8'h08);
    reg_read("R4 page readback", 8'h07, 8'h08);
    reg_read("R4 enable unchanged by off-page write", 8'h30, 8'h00);

    // R5/R6/R7 countdown in seconds
    reg_write(8'h30, 8'hFF);
    reg_read("R8 enable reads only bit0", 8'h30, 8'h01);
    reg_write(8'hF6, 8'h03);
    reg_read("R5 count load", 8'hF6, 8'h03);
    tick(); tick();
    reg_read("R5 count after two ticks", 8'hF6, 8'h01);
    tick();
    check("R6 pulse cycle after tick", {7'b0, wdt_reset}, 8'h01);
    @(negedge clk);
    check("R6 pulse one cycle", {7'b0, wdt_reset}, 8'h00);
    check("R6 pulse count", 8'(pulses), 8'd1);
    tick(); tick();
    @(negedge clk);
    check("R7 no repeat pulse", 8'(pulses), 8'd1);
    reg_read("R7 count holds zero", 8'hF6, 8'h00);

    // R8 freeze
    reg_write(8'hF6, 8'h05);
    reg_write(8'h30, 8'h00);
    tick(); tick();
    reg_read("R8 frozen while disabled", 8'hF6, 8'h05);
    reg_write(8'h30, 8'h01);

    // R9 minutes
    reg_write(8'hF5, 8'hFF);
    reg_read("R9 unit reads only bit3", 8'hF5, 8'h08);
    reg_write(8'hF6, 8'h02);
    for (int i = 0; i < 59; i++) tick();
    reg_read("R9 no step before 60 ticks", 8'hF6, 8'h02);
    tick();
    reg_read("R9 step at 60th tick", 8'hF6, 8'h01);
    reg_write(8'hF5, 8'h00);

    // R10 event reloads
    reg_write(8'hF7, 8'h40);
    reg_write(8'hF6, 8'h04);
    tick(); tick();
    reg_read("R10 before kbd", 8'hF6, 8'h02);
    pulse_evt(1'b0);
    reg_read("R10 kbd reload", 8'hF6, 8'h04);
    tick();
    pulse_evt(1'b1);
    reg_read("R10 mouse ignored when bit7 clear", 8'hF6, 8'h03);
    reg_write(8'hF7, 8'hFF);
    reg_read("R10 source reads only bits 6 and 7", 8'hF7, 8'hC0);
    pulse_evt(1'b1);
    reg_read("R10 mouse reload", 8'hF6, 8'h04);

    // R3 close and keep counting
    reg_write(8'hF6, 8'h02);
    idx_write(8'hAA);
    expect_read("R3 closed after AA", 8'hFF);
    tick(); tick();
    @(negedge clk);
    check("R3 counting continues while closed", 8'(pulses), 8'd2);

    repeat (4) @(negedge clk);
    check("R1 scoreboard drained", 8'(exp_q.size()), 8'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule